// File: doc/BRIEF.md
# Loop Jump Target Cache

This block sits between instruction fetch and decode of a four-stage pipeline. It removes the fetch bubble from conditional jumps that repeat inside a loop. The decode stage presents a jump descriptor each cycle: a valid flag, the jump's own address, a class code and the condition outcome. A taken jump normally costs one extra machine cycle, because its target must be fetched. The block raises a stall request for that cycle.

When a cacheable jump is taken and misses, the block remembers the jump's address. In the next cycle it captures the target instruction word and the target's address as fetch returns them. A later taken pass of the same jump hits. The block then presents the stored word for direct injection into decode, together with the address that fetch should resume from. No stall is requested on a hit.

The single entry is dropped whenever the pipeline reports an instruction that can change the code segment, or an interrupt being serviced. The next pass of the jump then pays the fetch penalty again.

Top module: `loop_jump_cache`

## Requirements
- R1: After a synchronous active-low reset, the entry is invalid. With idle inputs, `hit` and `stall` are both 0.
- R2: A descriptor with the condition false, or with class code 0 (not a jump), gives `hit`=0 and `stall`=0. The sequential instruction therefore proceeds with no extra cycle.
- R3: A taken cacheable jump (class code 1) that misses gives `stall`=1 and `hit`=0 in its decode cycle. `hit` and `stall` are never 1 together.
- R4: A fill needs the target word and its address on `fetch_instr` and `fetch_addr`, with `fetch_valid`=1, in the cycle directly after the missing decode. The next taken class-1 pass at the same address then gives `hit`=1 and `stall`=0. That pass also gives `inj_instr` equal to the captured word and `inj_resume` equal to the captured target address plus 1.
- R5: Class codes 2 and 3 (other branches) give `stall`=1 when taken. They never hit and never fill the entry. A cached class-1 entry at the same address survives them.
- R6: A taken class-1 jump at a different address from the stored tag misses. Its fill replaces the entry, so the old jump misses on its next pass.
- R7: `seg_change`=1 invalidates the entry. The next taken pass of a cached jump stalls.
- R8: `irq_taken`=1 invalidates the entry. The next taken pass of a cached jump stalls.
- R9: An invalidation wins over any same-cycle hit or fill. A taken class-1 decode in that cycle gives `hit`=0 and `stall`=1 and starts no fill. A fill cycle that coincides with an invalidation leaves the entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_pc | input | AW | Address of the instruction in decode |
| dec_class | input | 2 | 0 not a jump, 1 cacheable conditional jump, 2/3 other branch |
| dec_taken | input | 1 | Jump condition is true |
| fetch_valid | input | 1 | Fetch returns a target word this cycle |
| fetch_instr | input | IW | Fetched target instruction word |
| fetch_addr | input | AW | Address of the fetched target word |
| seg_change | input | 1 | A code-segment-changing instruction executes |
| irq_taken | input | 1 | A standard interrupt is serviced |
| hit | output | 1 | Inject the cached target into decode |
| inj_instr | output | IW | Cached target instruction word |
| inj_resume | output | AW | Address at which fetch resumes after injection |
| stall | output | 1 | One-cycle fetch bubble requested |

## Verification
An invalidation can fall in the same cycle as a taken decode of the cached jump. It can also fall in the cycle where a target word returns for a pending fill. The bench provokes both collisions on purpose in directed steps. A long pseudo-random stretch also mixes interrupt and segment-change pulses freely with loop passes and fills. Each cycle is judged against a bench model of the entry. That model lets the invalidation win: no hit, a stall for the taken jump, and no fill.

// File: rtl/lj_pkg.sv
// Shared class codes for the loop jump target cache.
package lj_pkg;
    typedef enum logic [1:0] {
        JC_NONE      = 2'd0,
        JC_CACHEABLE = 2'd1,
        JC_OTHER     = 2'd2,
        JC_OTHER_B   = 2'd3
    } jclass_t;
endpackage

// File: rtl/lj_match.sv
// Decode-side lookup: compares the decode descriptor with the entry.
// It produces the hit, the stall request and the fill-start pulse.
// Assumes the entry outputs are registered, so the result is combinational.
module lj_match #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [1:0]    dec_class,
    input  logic          dec_taken,
    input  logic [AW-1:0] dec_pc,
    input  logic          ent_valid,
    input  logic [AW-1:0] ent_tag,
    input  logic          flush,
    output logic          hit,
    output logic          miss_fill,
    output logic          stall
);
    logic is_branch;
    logic is_cacheable;
    logic taken_br;

    // Classify the decode descriptor and resolve hit, stall and fill start.
    always_comb begin
        is_branch    = dec_class != lj_pkg::JC_NONE;
        is_cacheable = dec_class == lj_pkg::JC_CACHEABLE;
        taken_br     = dec_valid && dec_taken && is_branch;
        hit          = taken_br && is_cacheable && ent_valid
                       && (ent_tag == dec_pc) && !flush;
        miss_fill    = taken_br && is_cacheable && !hit && !flush;
        stall        = taken_br && !hit;
    end

    AST_HIT_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (dec_class == lj_pkg::JC_CACHEABLE)); // R5
    AST_HIT_NOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && stall)); // R3
endmodule

// File: rtl/lj_fill_ctrl.sv
// Fill sequencer: remembers the tag of a missing jump for one cycle.
// It turns the returning fetch word into an entry write.
// Assumes the target word arrives in the cycle after the miss.
module lj_fill_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_fill,
    input  logic [AW-1:0] dec_pc,
    input  logic          fetch_valid,
    input  logic          flush,
    output logic          wr_en,
    output logic [AW-1:0] wr_tag
);
    logic          pend_q;
    logic [AW-1:0] ptag_q;

    // Hold the pending-fill flag and tag for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ptag_q <= '0;
        end else begin
            pend_q <= miss_fill && !flush;
            if (miss_fill) ptag_q <= dec_pc;
        end
    end

    // Issue the entry write when the target word returns and no flush is present.
    always_comb begin
        wr_en  = fetch_valid && pend_q && !flush;
        wr_tag = ptag_q;
    end

    AST_WRITE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(miss_fill)); // R4
endmodule

// File: rtl/lj_entry.sv
// Single cache entry: valid bit, jump tag, target word and target address.
// Invalidation has priority over a write in the same cycle.
module lj_entry #(
    parameter int AW = 8,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_tag,
    input  logic [IW-1:0] wr_instr,
    input  logic [AW-1:0] wr_tgt,
    output logic          valid,
    output logic [AW-1:0] tag,
    output logic [IW-1:0] instr,
    output logic [AW-1:0] tgt
);
    logic          valid_q;
    logic [AW-1:0] tag_q;
    logic [IW-1:0] instr_q;
    logic [AW-1:0] tgt_q;

    // Update the valid bit: reset and flush clear it, a write sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= 1'b0;
        else if (flush)  valid_q <= 1'b0;
        else if (wr_en)  valid_q <= 1'b1;
    end

    // Capture the tag and payload on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            instr_q <= '0;
            tgt_q   <= '0;
        end else if (wr_en) begin
            tag_q   <= wr_tag;
            instr_q <= wr_instr;
            tgt_q   <= wr_tgt;
        end
    end

    assign valid = valid_q;
    assign tag   = tag_q;
    assign instr = instr_q;
    assign tgt   = tgt_q;

    AST_RESET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid_q); // R1
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_q); // R9
    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (valid_q && tag_q == $past(wr_tag))); // R4
endmodule

// File: rtl/loop_jump_cache.sv
// Loop jump target cache top. It injects a stored target word into decode
// on repeated taken passes of a cacheable jump. Any segment change or
// interrupt drops the entry. Assumes a word-addressed fetch stream,
// so the instruction after the target sits at target address + 1.
module loop_jump_cache #(
    parameter int AW = 8,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_pc,
    input  logic [1:0]    dec_class,
    input  logic          dec_taken,
    input  logic          fetch_valid,
    input  logic [IW-1:0] fetch_instr,
    input  logic [AW-1:0] fetch_addr,
    input  logic          seg_change,
    input  logic          irq_taken,
    output logic          hit,
    output logic [IW-1:0] inj_instr,
    output logic [AW-1:0] inj_resume,
    output logic          stall
);
    localparam logic [AW-1:0] STEP = AW'(1);

    logic          flush;
    logic          miss_fill;
    logic          wr_en;
    logic [AW-1:0] wr_tag;
    logic          ent_valid;
    logic [AW-1:0] ent_tag;
    logic [AW-1:0] ent_tgt;

    assign flush = seg_change || irq_taken;

    lj_match #(.AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_class(dec_class), .dec_taken(dec_taken),
        .dec_pc(dec_pc), .ent_valid(ent_valid), .ent_tag(ent_tag),
        .flush(flush), .hit(hit), .miss_fill(miss_fill), .stall(stall)
    );

    lj_fill_ctrl #(.AW(AW)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .miss_fill(miss_fill), .dec_pc(dec_pc), .fetch_valid(fetch_valid),
        .flush(flush), .wr_en(wr_en), .wr_tag(wr_tag)
    );

    lj_entry #(.AW(AW), .IW(IW)) u_entry (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .wr_en(wr_en), .wr_tag(wr_tag),
        .wr_instr(fetch_instr), .wr_tgt(fetch_addr),
        .valid(ent_valid), .tag(ent_tag), .instr(inj_instr), .tgt(ent_tgt)
    );

    // Resume fetch at the word after the injected target.
    assign inj_resume = ent_tgt + STEP;

    AST_NO_HIT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_change || irq_taken) |=> !hit); // R7
    AST_NO_HIT_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !hit); // R8
endmodule

// File: tb/loop_jump_cache_test.sv
module loop_jump_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [7:0]  dec_pc = '0;
    logic [1:0]  dec_class = '0;
    logic        dec_taken = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_instr = '0;
    logic [7:0]  fetch_addr = '0;
    logic        seg_change = 1'b0;
    logic        irq_taken = 1'b0;
    logic        hit;
    logic [15:0] inj_instr;
    logic [7:0]  inj_resume;
    logic        stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the entry, built from the requirements.
    bit        m_valid = 0;
    bit [7:0]  m_tag = 0;
    bit [15:0] m_instr = 0;
    bit [7:0]  m_tgt = 0;
    bit        m_pend = 0;
    bit [7:0]  m_ptag = 0;

    always #10 clk = ~clk;

    loop_jump_cache uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc),
        .dec_class(dec_class), .dec_taken(dec_taken), .fetch_valid(fetch_valid),
        .fetch_instr(fetch_instr), .fetch_addr(fetch_addr), .seg_change(seg_change),
        .irq_taken(irq_taken), .hit(hit), .inj_instr(inj_instr),
        .inj_resume(inj_resume), .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One machine cycle: drive, check against the model, clock, update the model.
    task automatic cyc(input bit dv, input bit [1:0] cls, input bit tk, input bit [7:0] pc,
                       input bit fv, input bit [15:0] fi, input bit [7:0] fa,
                       input bit sc, input bit iq, input string req);
        bit fl, tbr, eh, es, fs;
        @(negedge clk);
        dec_valid = dv; dec_class = cls; dec_taken = tk; dec_pc = pc;
        fetch_valid = fv; fetch_instr = fi; fetch_addr = fa;
        seg_change = sc; irq_taken = iq;
        #3;
        fl  = sc || iq;
        tbr = dv && tk && (cls != 2'd0);
        eh  = tbr && cls == 2'd1 && m_valid && m_tag == pc && !fl;
        es  = tbr && !eh;
        fs  = tbr && cls == 2'd1 && !eh && !fl;
        chk(hit == eh, req, "hit", hit, eh);
        chk(stall == es, req, "stall", stall, es);
        if (eh) begin
            chk(inj_instr == m_instr, req, "inj_instr", inj_instr, m_instr);
            chk(inj_resume == m_tgt + 8'd1, req, "inj_resume", inj_resume, m_tgt + 8'd1);
        end
        @(posedge clk);
        if (fl) m_valid = 0;
        else if (fv && m_pend) begin
            m_valid = 1; m_tag = m_ptag; m_instr = fi; m_tgt = fa;
        end
        m_pend = fs;
        if (fs) m_ptag = pc;
    endtask

    task automatic idle(input string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic jmp(input bit [1:0] cls, input bit tk, input bit [7:0] pc, input string req);
        cyc(1, cls, tk, pc, 0, 0, 0, 0, 0, req);
    endtask

    task automatic ret(input bit [15:0] w, input bit [7:0] a, input string req);
        cyc(0, 0, 0, 0, 1, w, a, 0, 0, req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle("R1");
        // R2: not-taken and non-jump descriptors
        jmp(1, 0, 8'h20, "R2");
        jmp(0, 1, 8'h20, "R2");
        // R3: first taken pass stalls; R4: fill then hits on later passes
        jmp(1, 1, 8'h20, "R3");
        ret(16'hBEEF, 8'h10, "R4");
        idle("R4");
        for (int i = 0; i < 3; i++) begin
            jmp(1, 1, 8'h20, "R4");
            idle("R4");
        end
        // R8: interrupt brings the penalty back
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
        jmp(1, 1, 8'h20, "R8");
        ret(16'hBEEF, 8'h10, "R8");
        jmp(1, 1, 8'h20, "R8");
        // R7: segment change brings the penalty back
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
        jmp(1, 1, 8'h20, "R7");
        ret(16'hCAFE, 8'h11, "R7");
        jmp(1, 1, 8'h20, "R7");
        // R5: other classes stall, never hit, never fill
        jmp(2, 1, 8'h20, "R5");
        ret(16'h0BAD, 8'h77, "R5");
        jmp(3, 1, 8'h20, "R5");
        jmp(1, 1, 8'h20, "R5");
        // R6: different jump replaces the entry
        jmp(1, 1, 8'h30, "R6");
        ret(16'h1234, 8'h40, "R6");
        jmp(1, 1, 8'h30, "R6");
        jmp(1, 1, 8'h20, "R6");
        ret(16'hBEEF, 8'h10, "R6");
        // R9: invalidation in the same cycle as a hit, then during a fill
        cyc(1, 1, 1, 8'h20, 0, 0, 0, 0, 1, "R9");
        ret(16'hBEEF, 8'h10, "R9");
        jmp(1, 1, 8'h20, "R9");
        cyc(0, 0, 0, 0, 1, 16'hBEEF, 8'h10, 1, 0, "R9");
        jmp(1, 1, 8'h20, "R9");
        ret(16'hBEEF, 8'h10, "R9");
        jmp(1, 1, 8'h20, "R9");
        // Sweep: pseudo-random mix over a small address set
        for (int n = 0; n < 4000; n++) begin
            bit [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[3:2], r[4] | r[5], {7'h10, r[6]},
                r[7] | r[8], r[24:9], {4'h3, r[28:25]},
                (r[31:29] == 3'd0), (r[31:29] == 3'd7),
                (r[31:29] == 3'd0 || r[31:29] == 3'd7) ? "R9" :
                (r[3:2] >= 2'd2) ? "R5" : "R3");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule